// File: doc/BRIEF.md
# Triple Breakpoint and Printpoint Unit

This block watches the program counter of a processor being stepped one instruction at a time by a debug engine. It has three slots. Each slot holds a 16-bit match address, an 8-bit pass count and two enable bits, one for a breakpoint and one for a printpoint. After each stepped instruction the step engine presents the new PC with a valid strobe. The unit then answers with a stop request, a print request and the index of the slot that fired.

When the breakpoint of a slot is enabled, its pass count counts down on every match, and the stop fires on the match that uses up the count. When the printpoint of a slot is enabled, it raises a print request on every match and never stops the run. A single counter tracks how many instructions the current run has executed. It can also stop the run once an optional limit is reached. A small register port writes addresses, counts and enables, either to one slot or to all slots at once. A read port returns the state of any slot, including the pass count left over after a run.

Top module: `bkpt_unit`

## Requirements
- R1: After reset both enables of every slot are 0, every slot reads back address 0 and count 0, the instruction count is 0, and stop_o, stop_bp_o, print_o and hit_idx_o are all 0.
- R2: A write with reg_sel_i equal to a slot index 0..2 acts on that slot only. reg_field_i selects the action: 0 loads the address from reg_wdata_i[15:0], 1 loads the pass count from reg_wdata_i[7:0], 2 sets the breakpoint enable, 3 clears it, 4 sets the printpoint enable and 5 clears it. The read port shows the addressed slot's address, count and enables in the same cycle as rd_sel_i.
- R3: reg_sel_i = 3 selects the group. With field codes 2..5 the enable action applies to all three slots at once. With field codes 0 and 1 the write is ignored and no slot changes.
- R4: A step is a cycle in which pc_valid_i and step_mode_i are both 1. stop_o, stop_bp_o and print_o are one-cycle pulses in the cycle after a step and are 0 otherwise. When step_mode_i is 0, pc_valid_i causes no match and no counting.
- R5: On a step where pc_i equals the slot address and the breakpoint is enabled, a nonzero pass count decrements by one and a zero count stays zero. A stop fires when the count before the step was 0 or 1, so a count of N stops on the Nth match and counts 0 and 1 behave alike. The remaining count is kept and can be read back. A slot with its breakpoint disabled never decrements.
- R6: A matching slot with its printpoint enabled raises print_o on every match whatever its pass count is, and on its own it raises no stop.
- R7: One slot may have both enables set. Each function then acts independently on the same address.
- R8: hit_idx_o reports the lowest-numbered slot that raised a stop or a print on that step, or 0 if none did. Every matching slot with its breakpoint enabled still decrements its count.
- R9: run_start_i clears the instruction count and latches limit_i. With a limit N other than 0, the step that takes the count to N raises stop_o with stop_bp_o at 0. A limit of 0 never stops the run. stop_bp_o is 1 exactly when a breakpoint caused the stop, whether or not the limit was reached.
- R10: instr_count_o gives the number of steps since the last run_start_i and is updated in the same cycle as stop_o. It saturates at 0xFFFF instead of wrapping, and a saturated count never triggers a limit stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_mode_i | input | 1 | 1 while the processor is being single-stepped |
| run_start_i | input | 1 | Starts a run: clears the instruction count and latches the limit |
| limit_i | input | 16 | Instruction limit, 0 means no limit |
| pc_valid_i | input | 1 | PC after a stepped instruction is valid |
| pc_i | input | 16 | PC value |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Slot index 0..2, or 3 for all slots |
| reg_field_i | input | 3 | Write action code |
| reg_wdata_i | input | 16 | Write data |
| rd_sel_i | input | 2 | Slot shown on the read port |
| rd_addr_o | output | 16 | Address of the selected slot |
| rd_count_o | output | 8 | Pass count of the selected slot |
| rd_bp_en_o | output | 1 | Breakpoint enable of the selected slot |
| rd_pp_en_o | output | 1 | Printpoint enable of the selected slot |
| stop_o | output | 1 | Stop request, from a breakpoint or the limit |
| stop_bp_o | output | 1 | The stop came from a breakpoint |
| print_o | output | 1 | Print request |
| hit_idx_o | output | 2 | Lowest slot that fired |
| instr_count_o | output | 16 | Instructions executed in this run |

## Verification
Pass counts from 0 to 5 are each driven at a single matching address. This separates the stop on the Nth match from an early or late stop, and a run that ends early leaves a residue that is then read back. All three slots are loaded with one shared address under different mixes of enables, which tests the lowest-index rule and confirms that every matching slot still decrements. A long stream of pseudo-random steps mixed with register writes is drawn from a small address range, so overlaps, group writes and limit restarts happen often. The count is then driven past 0xFFFF to show that it saturates and that the saturated value sets off no limit stop.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned CNT_W     = 8;
  localparam int unsigned ICNT_W    = 16;
  localparam int unsigned NUM_SLOTS = 3;

  typedef enum logic [2:0] {
    FLD_ADDR   = 3'd0,
    FLD_CNT    = 3'd1,
    FLD_BP_ON  = 3'd2,
    FLD_BP_OFF = 3'd3,
    FLD_PP_ON  = 3'd4,
    FLD_PP_OFF = 3'd5
  } reg_field_e;
endpackage

// File: rtl/bkpt_slot.sv
module bkpt_slot #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_we_i,
  input  logic          cnt_we_i,
  input  logic          bp_set_i,
  input  logic          bp_clr_i,
  input  logic          pp_set_i,
  input  logic          pp_clr_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          step_i,
  input  logic [AW-1:0] pc_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cnt_o,
  output logic          bp_en_o,
  output logic          pp_en_o,
  output logic          bp_fire_o,
  output logic          pp_fire_o
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          bp_q, pp_q;
  logic          match, bp_match;

  assign match     = step_i && (pc_i == addr_q);
  assign bp_match  = match && bp_q;
  // count of 0 or 1 means this match is the last one
  assign bp_fire_o = bp_match && (cnt_q <= CW'(1));
  assign pp_fire_o = match && pp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
      bp_q   <= 1'b0;
      pp_q   <= 1'b0;
    end else begin
      if (addr_we_i) addr_q <= wdata_i;
      if (cnt_we_i)                      cnt_q <= wdata_i[CW-1:0];
      else if (bp_match && cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
      if (bp_set_i)      bp_q <= 1'b1;
      else if (bp_clr_i) bp_q <= 1'b0;
      if (pp_set_i)      pp_q <= 1'b1;
      else if (pp_clr_i) pp_q <= 1'b0;
    end
  end

  assign addr_o  = addr_q;
  assign cnt_o   = cnt_q;
  assign bp_en_o = bp_q;
  assign pp_en_o = pp_q;
endmodule

// File: rtl/hit_select.sv
module hit_select #(
  parameter int unsigned N  = 3,
  parameter int unsigned SW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [SW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = SW'(i);
    end
  end
  assign found_o = |req_i;
endmodule

// File: rtl/instr_counter.sv
module instr_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] limit_i,
  input  logic         step_i,
  output logic [W-1:0] count_o,
  output logic         limit_hit_o
);
  logic [W-1:0] cnt_q, lim_q;
  logic [W:0]   nxt;

  assign nxt = {1'b0, cnt_q} + (W+1)'(1);
  // compare the unsaturated sum so a pinned count never re-fires
  assign limit_hit_o = step_i && (lim_q != '0) && (nxt == {1'b0, lim_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
      lim_q <= limit_i;
    end else if (step_i) begin
      cnt_q <= nxt[W] ? '1 : nxt[W-1:0];
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit #(
  parameter int unsigned NUM_SLOTS = bkpt_pkg::NUM_SLOTS,
  parameter int unsigned ADDR_W    = bkpt_pkg::ADDR_W,
  parameter int unsigned CNT_W     = bkpt_pkg::CNT_W,
  parameter int unsigned ICNT_W    = bkpt_pkg::ICNT_W,
  localparam int unsigned SEL_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_mode_i,
  input  logic              run_start_i,
  input  logic [ICNT_W-1:0] limit_i,
  input  logic              pc_valid_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              reg_we_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic [2:0]        reg_field_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [CNT_W-1:0]  rd_count_o,
  output logic              rd_bp_en_o,
  output logic              rd_pp_en_o,
  output logic              stop_o,
  output logic              stop_bp_o,
  output logic              print_o,
  output logic [SEL_W-1:0]  hit_idx_o,
  output logic [ICNT_W-1:0] instr_count_o
);
  import bkpt_pkg::*;

  localparam logic [SEL_W-1:0] SEL_ALL = SEL_W'(NUM_SLOTS);

  reg_field_e           fld;
  logic                 step;
  logic                 grp_we;
  logic [NUM_SLOTS-1:0] bp_fire, pp_fire, bp_en, pp_en;
  logic [ADDR_W-1:0]    s_addr [NUM_SLOTS];
  logic [CNT_W-1:0]     s_cnt  [NUM_SLOTS];
  logic                 found, limit_hit;
  logic [SEL_W-1:0]     idx;

  assign fld    = reg_field_e'(reg_field_i);
  assign step   = pc_valid_i && step_mode_i;
  assign grp_we = reg_we_i && (reg_sel_i == SEL_ALL);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic one_we, any_we;
    assign one_we = reg_we_i && (reg_sel_i == SEL_W'(g));
    assign any_we = one_we || grp_we;

    bkpt_slot #(.AW(ADDR_W), .CW(CNT_W)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .addr_we_i (one_we && fld == FLD_ADDR),
      .cnt_we_i  (one_we && fld == FLD_CNT),
      .bp_set_i  (any_we && fld == FLD_BP_ON),
      .bp_clr_i  (any_we && fld == FLD_BP_OFF),
      .pp_set_i  (any_we && fld == FLD_PP_ON),
      .pp_clr_i  (any_we && fld == FLD_PP_OFF),
      .wdata_i   (reg_wdata_i),
      .step_i    (step),
      .pc_i      (pc_i),
      .addr_o    (s_addr[g]),
      .cnt_o     (s_cnt[g]),
      .bp_en_o   (bp_en[g]),
      .pp_en_o   (pp_en[g]),
      .bp_fire_o (bp_fire[g]),
      .pp_fire_o (pp_fire[g])
    );
  end

  hit_select #(.N(NUM_SLOTS), .SW(SEL_W)) u_sel (
    .req_i   (bp_fire | pp_fire),
    .found_o (found),
    .idx_o   (idx)
  );

  instr_counter #(.W(ICNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (run_start_i),
    .limit_i     (limit_i),
    .step_i      (step),
    .count_o     (instr_count_o),
    .limit_hit_o (limit_hit)
  );

  always_comb begin
    rd_addr_o  = '0;
    rd_count_o = '0;
    rd_bp_en_o = 1'b0;
    rd_pp_en_o = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (rd_sel_i == SEL_W'(i)) begin
        rd_addr_o  = s_addr[i];
        rd_count_o = s_cnt[i];
        rd_bp_en_o = bp_en[i];
        rd_pp_en_o = pp_en[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_o    <= 1'b0;
      stop_bp_o <= 1'b0;
      print_o   <= 1'b0;
      hit_idx_o <= '0;
    end else begin
      stop_o    <= (|bp_fire) || limit_hit;
      stop_bp_o <= |bp_fire;
      print_o   <= |pp_fire;
      hit_idx_o <= found ? idx : '0;
    end
  end
endmodule

// File: rtl/bkpt_unit_chk.sv
module bkpt_unit_chk #(
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned ICNT_W = 16,
  parameter int unsigned NSLOT  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              step_mode_i,
  input logic              pc_valid_i,
  input logic              run_start_i,
  input logic              stop_o,
  input logic              stop_bp_o,
  input logic              print_o,
  input logic [SEL_W-1:0]  hit_idx_o,
  input logic [ICNT_W-1:0] instr_count_o
);
  assert_pulse_needs_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o || print_o) |-> $past(pc_valid_i && step_mode_i));

  assert_freerun_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_mode_i |=> (!stop_o && !print_o && !stop_bp_o));

  assert_bp_is_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_bp_o |-> stop_o);

  assert_idx_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_idx_o < SEL_W'(NSLOT));

  assert_count_saturates_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(instr_count_o) == '1 && !$past(run_start_i)) |-> instr_count_o == '1);

  assert_count_monotonic_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_start_i) |-> instr_count_o >= $past(instr_count_o));

  assert_count_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(pc_valid_i && step_mode_i) && !$past(run_start_i)) |-> $stable(instr_count_o));
endmodule

bind bkpt_unit bkpt_unit_chk #(.SEL_W(SEL_W), .ICNT_W(ICNT_W), .NSLOT(NUM_SLOTS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .step_mode_i   (step_mode_i),
  .pc_valid_i    (pc_valid_i),
  .run_start_i   (run_start_i),
  .stop_o        (stop_o),
  .stop_bp_o     (stop_bp_o),
  .print_o       (print_o),
  .hit_idx_o     (hit_idx_o),
  .instr_count_o (instr_count_o)
);

// File: tb/tb_bkpt_unit.sv
`timescale 1ns/1ps
module tb_bkpt_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic step_mode = 1'b1, run_start = 1'b0, pc_valid = 1'b0, reg_we = 1'b0;
  logic [15:0] limit = '0, pc_in = '0, wdata = '0;
  logic [1:0]  reg_sel = '0, rd_sel = '0;
  logic [2:0]  reg_field = '0;
  logic [15:0] rd_addr, icnt;
  logic [7:0]  rd_count;
  logic rd_bp, rd_pp, stop, stop_bp, prt;
  logic [1:0] hit_idx;

  bkpt_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .step_mode_i(step_mode), .run_start_i(run_start),
    .limit_i(limit), .pc_valid_i(pc_valid), .pc_i(pc_in), .reg_we_i(reg_we),
    .reg_sel_i(reg_sel), .reg_field_i(reg_field), .reg_wdata_i(wdata), .rd_sel_i(rd_sel),
    .rd_addr_o(rd_addr), .rd_count_o(rd_count), .rd_bp_en_o(rd_bp), .rd_pp_en_o(rd_pp),
    .stop_o(stop), .stop_bp_o(stop_bp), .print_o(prt), .hit_idx_o(hit_idx),
    .instr_count_o(icnt));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [15:0] m_addr [3];
  logic [7:0]  m_cnt  [3];
  logic        m_bp [3], m_pp [3];
  logic [15:0] m_icnt, m_lim;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp<190000", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      m_addr[i] = '0; m_cnt[i] = '0; m_bp[i] = 1'b0; m_pp[i] = 1'b0;
    end
    m_icnt = '0; m_lim = '0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [2:0] fld, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_field = fld; wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (sel == 2'(i) && fld == 3'd0) m_addr[i] = d;
      if (sel == 2'(i) && fld == 3'd1) m_cnt[i] = d[7:0];
      if (sel == 2'(i) || sel == 2'd3) begin
        case (fld)
          3'd2: m_bp[i] = 1'b1;
          3'd3: m_bp[i] = 1'b0;
          3'd4: m_pp[i] = 1'b1;
          3'd5: m_pp[i] = 1'b0;
          default: ;
        endcase
      end
    end
  endtask

  task automatic rd_chk(input int s, input string tag);
    rd_sel = 2'(s);
    #1;
    chk({tag, " addr"}, 32'(rd_addr), 32'(m_addr[s]));
    chk({tag, " cnt"},  32'(rd_count), 32'(m_cnt[s]));
    chk({tag, " bp"},   32'(rd_bp), 32'(m_bp[s]));
    chk({tag, " pp"},   32'(rd_pp), 32'(m_pp[s]));
  endtask

  task automatic start_run(input logic [15:0] lim);
    @(negedge clk);
    run_start = 1'b1; limit = lim;
    @(negedge clk);
    run_start = 1'b0;
    m_icnt = '0; m_lim = lim;
  endtask

  task automatic do_step(input logic [15:0] pc, input string tag);
    logic e_bp, e_pr, e_lim, fnd;
    logic [1:0] e_idx;
    logic [16:0] nx;
    e_bp = 0; e_pr = 0; fnd = 0; e_idx = 0;
    for (int i = 0; i < 3; i++) begin
      logic mt, bf, pf;
      mt = (pc == m_addr[i]);
      bf = mt && m_bp[i] && (m_cnt[i] <= 8'd1);
      pf = mt && m_pp[i];
      if (mt && m_bp[i] && m_cnt[i] != 0) m_cnt[i] = m_cnt[i] - 8'd1;
      if ((bf || pf) && !fnd) begin e_idx = 2'(i); fnd = 1; end
      e_bp |= bf; e_pr |= pf;
    end
    nx = {1'b0, m_icnt} + 17'd1;
    e_lim = (m_lim != 0) && (nx == {1'b0, m_lim});
    m_icnt = nx[16] ? 16'hFFFF : nx[15:0];
    @(negedge clk);
    pc_valid = 1'b1; pc_in = pc;
    @(negedge clk);
    pc_valid = 1'b0;
    chk({tag, " stop"},  32'(stop), 32'(e_bp || e_lim));
    chk({tag, " stopbp"}, 32'(stop_bp), 32'(e_bp));
    chk({tag, " print"}, 32'(prt), 32'(e_pr));
    chk({tag, " idx"},   32'(hit_idx), 32'(e_idx));
    chk({tag, " icnt"},  32'(icnt), 32'(m_icnt));
  endtask

  initial begin
    logic [15:0] lfsr;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 stop", 32'(stop), 0);
    chk("R1 print", 32'(prt), 0);
    chk("R1 stopbp", 32'(stop_bp), 0);
    chk("R1 idx", 32'(hit_idx), 0);
    chk("R1 icnt", 32'(icnt), 0);
    for (int s = 0; s < 3; s++) rd_chk(s, "R1");
    rst_n = 1'b1;
    @(negedge clk);

    // R2: per-slot writes and readback
    for (int s = 0; s < 3; s++) begin
      wr(2'(s), 3'd0, 16'h1000 + 16'(s) * 16'h0111);
      wr(2'(s), 3'd1, 16'(8'h20 + 8'(s)));
    end
    wr(2'd1, 3'd2, 0); wr(2'd2, 3'd4, 0);
    for (int s = 0; s < 3; s++) rd_chk(s, "R2");
    wr(2'd1, 3'd3, 0); wr(2'd2, 3'd5, 0);
    for (int s = 0; s < 3; s++) rd_chk(s, "R2");

    // R3: group enables; group address and count writes ignored
    wr(2'd3, 3'd2, 0); wr(2'd3, 3'd4, 0);
    for (int s = 0; s < 3; s++) rd_chk(s, "R3");
    wr(2'd3, 3'd0, 16'hBEEF); wr(2'd3, 3'd1, 16'h0077);
    for (int s = 0; s < 3; s++) rd_chk(s, "R3");
    wr(2'd3, 3'd3, 0); wr(2'd3, 3'd5, 0);
    for (int s = 0; s < 3; s++) rd_chk(s, "R3");

    // R4: free-running steps are ignored
    wr(2'd0, 3'd1, 1); wr(2'd0, 3'd2, 0); wr(2'd0, 3'd4, 0);
    start_run(16'd0);
    @(negedge clk);
    step_mode = 1'b0; pc_valid = 1'b1; pc_in = m_addr[0];
    @(negedge clk);
    pc_valid = 1'b0;
    chk("R4 freerun stop", 32'(stop), 0);
    chk("R4 freerun print", 32'(prt), 0);
    chk("R4 freerun icnt", 32'(icnt), 0);
    step_mode = 1'b1;
    rd_chk(0, "R4");
    do_step(m_addr[0], "R4");
    chk("R4 pulse", 32'(stop), 1);
    @(negedge clk);
    chk("R4 pulse end", 32'(stop), 0);

    // R5: pass count sweep 0..5 on slot 1
    wr(2'd3, 3'd3, 0); wr(2'd3, 3'd5, 0);
    wr(2'd1, 3'd0, 16'h1234); wr(2'd1, 3'd2, 0);
    for (int n = 0; n <= 5; n++) begin
      wr(2'd1, 3'd1, 16'(n));
      start_run(16'd0);
      for (int k = 1; k <= ((n == 0) ? 1 : n); k++) begin
        do_step(16'h1234, "R5");
        chk("R5 stop at Nth", 32'(stop), 32'(k == ((n == 0) ? 1 : n)));
      end
      rd_chk(1, "R5 residue");
    end
    wr(2'd1, 3'd1, 5); start_run(0);
    repeat (3) do_step(16'h1234, "R5");
    rd_chk(1, "R5 early end");
    chk("R5 residue 2", 32'(rd_count), 2);
    wr(2'd1, 3'd3, 0);
    do_step(16'h1234, "R5 disabled");
    rd_chk(1, "R5 no decrement");

    // R6: printpoint ignores count, no stop
    wr(2'd0, 3'd0, 16'h2222); wr(2'd0, 3'd1, 3); wr(2'd0, 3'd4, 0);
    repeat (4) do_step(16'h2222, "R6");
    rd_chk(0, "R6 count kept");

    // R7: both functions on one slot
    wr(2'd2, 3'd0, 16'h3333); wr(2'd2, 3'd1, 2);
    wr(2'd2, 3'd2, 0); wr(2'd2, 3'd4, 0);
    repeat (3) do_step(16'h3333, "R7");
    rd_chk(2, "R7");

    // R8: overlapping addresses
    for (int s = 0; s < 3; s++) begin
      wr(2'(s), 3'd0, 16'h4444); wr(2'(s), 3'd1, 16'(s + 1));
    end
    wr(2'd3, 3'd5, 0); wr(2'd0, 3'd3, 0);
    wr(2'd1, 3'd2, 0); wr(2'd2, 3'd2, 0); wr(2'd2, 3'd4, 0);
    repeat (3) do_step(16'h4444, "R8");
    for (int s = 0; s < 3; s++) rd_chk(s, "R8");
    wr(2'd0, 3'd4, 0);
    do_step(16'h4444, "R8 lowest");

    // R9: instruction limit
    wr(2'd3, 3'd3, 0); wr(2'd3, 3'd5, 0);
    start_run(16'd7);
    for (int k = 1; k <= 8; k++) do_step(16'h9999, "R9 limit");
    start_run(16'd0);
    repeat (20) do_step(16'h9999, "R9 nolimit");
    wr(2'd0, 3'd0, 16'h0500); wr(2'd0, 3'd1, 1); wr(2'd0, 3'd2, 0);
    start_run(16'd10);
    do_step(16'h9999, "R9"); do_step(16'h9999, "R9");
    do_step(16'h0500, "R9 bp first");

    // mixed pseudo-random stream over a small address range
    lfsr = 16'hACE1;
    for (int k = 0; k < 2500; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (k % 8 == 0) begin
        logic [2:0] f;
        f = 3'(lfsr[6:4] % 3'd6);
        wr(lfsr[3:2], f, (f == 3'd0) ? {13'd0, lfsr[9:7]} : {13'd0, lfsr[12:10]});
      end
      if (k % 64 == 0) start_run({11'd0, lfsr[15:11]});
      do_step({13'd0, lfsr[2:0]}, "R8 mix");
      if (k % 50 == 0) rd_chk(k % 3, "R2 mix");
    end

    // R10: saturation
    wr(2'd3, 3'd3, 0); wr(2'd3, 3'd5, 0);
    start_run(16'd0);
    @(negedge clk);
    pc_in = 16'hABCD; pc_valid = 1'b1;
    repeat (65534) @(negedge clk);
    pc_valid = 1'b0;
    m_icnt = 16'hFFFE;
    chk("R10 near top", 32'(icnt), 32'hFFFE);
    do_step(16'hABCD, "R10");
    do_step(16'hABCD, "R10 saturate");
    chk("R10 pinned", 32'(icnt), 32'hFFFF);
    start_run(16'hFFFF);
    m_icnt = 16'hFFFE;
    @(negedge clk);
    pc_valid = 1'b1;
    repeat (65534) @(negedge clk);
    pc_valid = 1'b0;
    do_step(16'hABCD, "R10 limit at top");
    do_step(16'hABCD, "R10 no refire");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule